// File: doc/BRIEF.md
# Ordered-Set Reception Status Detector

This block sits after the code-group decoder of a 1000BASE-X receive path. It watches a byte-wide stream in which every byte carries a control/data marker and a code-violation marker. It reports, one code group at a time, whether the traffic is configuration ordered sets, idle ordered sets, or ordered sets spoiled by bad data. The byte stream leaves on a GMII-style receive data bus. Each status flag is high in exactly the cycles in which the code groups it describes are on that bus.

To report a whole ordered set from its first byte, the block holds the stream in a fixed four-stage delay. When a set's leading comma is one stage away from the output, the three code groups behind it are already visible, so the block can classify the set before any of it is presented. After that leading group, the remaining groups of the set take the same flag. The block also keeps a small record of which kind of set the link was last carrying. Corrupted sets are flagged as invalid only while that record says idle or configuration traffic is in progress.

Top module: `osd_rx_status`

## Requirements
- R1: `rxd_out` equals the `rx_octet` value presented exactly four clock edges earlier. A flag that describes a code group is high in the same cycle as that group's byte on `rxd_out`.
- R2: A valid idle set is a comma (0xBC with `rx_ctrl`=1) followed by the data byte 0x50. Both groups of a valid idle set are output with `stat_idle` high.
- R3: A valid configuration set is a comma followed by a type byte of 0xB5 or 0x42 and then two configuration-word bytes. All four groups are output with `stat_cfg` high. Either type byte is accepted in any order.
- R4: Idle or configuration traffic is in progress when the last recognised set was an idle set, a configuration set, or a corrupted set. In that state, a group at a set boundary that carries a comma or a code violation but does not begin a valid set starts a corrupted set. It spans 2 groups if the traffic was idle and 4 if it was configuration, and every group in it is output with `stat_invalid` high.
- R5: A code violation (`rx_viol`=1) or a control marker on any data position of an ordered set disqualifies that set. This includes the byte after the comma. The set is then handled by R4.
- R6: Any other group at a set boundary, such as a start-of-packet delimiter or an ordinary data byte, is output with all three flags low. It ends the in-progress state, so later corrupted sets raise no flag until a valid set is seen again.
- R7: At most one of `stat_cfg`, `stat_idle`, `stat_invalid` is high in any cycle.
- R8: While `rst` is high at a clock edge, the delay stages, the flags and the in-progress state clear. After that edge, `rxd_out` is 0 and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one code group per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_octet | input | 8 | Decoded code-group byte |
| rx_ctrl | input | 1 | High when the byte is a control character |
| rx_viol | input | 1 | High when the code group failed to decode |
| rxd_out | output | 8 | Received byte after the four-stage delay |
| stat_cfg | output | 1 | Code group on `rxd_out` belongs to a configuration set |
| stat_idle | output | 1 | Code group on `rxd_out` belongs to an idle set |
| stat_invalid | output | 1 | Code group on `rxd_out` belongs to a corrupted set |

## Verification
The temporal checks on configuration sets assume that a configuration word never contains the byte 0xBC. Without that, a flagged 0xBC in the word would look like a new set's comma. The bench therefore builds configuration words only from other byte values. The latency check assumes nothing about the data and becomes active only after four clock edges out of reset. The stimulus is a single stream of several scenarios. It covers clean idles, alternating configuration types, violations and stray control characters in each data position, corrupted commas in both traffic states, and packet delimiters that end a run of sets. Each output group is compared against a model built from the requirements.

// File: rtl/osd_pkg.sv
package osd_pkg;

    localparam int BYTE_W     = 8;
    localparam int IDLE_LEN   = 2;
    localparam int CFG_LEN    = 4;
    localparam int LOOKAHEAD  = CFG_LEN - 1;
    localparam int PIPE_DEPTH = LOOKAHEAD + 1;
    localparam int CNT_W      = $clog2(CFG_LEN);

    localparam logic [BYTE_W-1:0] COMMA_OCT = 8'hBC;
    localparam logic [BYTE_W-1:0] IDLE_OCT  = 8'h50;
    localparam logic [BYTE_W-1:0] CFG1_OCT  = 8'hB5;
    localparam logic [BYTE_W-1:0] CFG2_OCT  = 8'h42;

    typedef struct packed {
        logic [BYTE_W-1:0] octet;
        logic              ctrl;
        logic              viol;
    } cgrp_t;

    typedef enum logic [1:0] {
        CLS_OTHER,
        CLS_IDLE,
        CLS_CFG,
        CLS_SUSPECT
    } cls_e;

    typedef enum logic [1:0] {
        SET_NONE,
        SET_IDLE,
        SET_CFG,
        SET_BAD
    } set_e;

    function automatic logic is_comma(input cgrp_t g);
        return g.ctrl && !g.viol && (g.octet == COMMA_OCT);
    endfunction

    function automatic logic is_clean_data(input cgrp_t g);
        return !g.ctrl && !g.viol;
    endfunction

    function automatic logic is_cfg_type(input logic [BYTE_W-1:0] b);
        return (b == CFG1_OCT) || (b == CFG2_OCT);
    endfunction

    function automatic logic looks_like_start(input cgrp_t g);
        return g.viol || (g.ctrl && (g.octet == COMMA_OCT));
    endfunction

    // Groups still to come after the leading group of a set of this kind.
    function automatic logic [CNT_W-1:0] tail_len(input set_e k);
        logic [CNT_W-1:0] n;
        n = '0;
        if (k == SET_IDLE) n = CNT_W'(IDLE_LEN - 1);
        if (k == SET_CFG)  n = CNT_W'(CFG_LEN - 1);
        return n;
    endfunction

endpackage

// File: rtl/osd_tap_line.sv
module osd_tap_line
    import osd_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  cgrp_t              din,
    output cgrp_t [DEPTH-1:0]  taps
);

    cgrp_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < DEPTH; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        assign taps[g] = stage_q[g];
    end

endmodule

// File: rtl/osd_set_classifier.sv
module osd_set_classifier
    import osd_pkg::*;
(
    input  cgrp_t lead,
    input  cgrp_t nxt1,
    input  cgrp_t nxt2,
    input  cgrp_t nxt3,
    output cls_e  cls
);

    logic head_ok;
    logic idle_tail_ok;
    logic cfg_tail_ok;

    always_comb begin
        head_ok      = is_comma(lead);
        idle_tail_ok = is_clean_data(nxt1) && (nxt1.octet == IDLE_OCT);
        cfg_tail_ok  = is_clean_data(nxt1) && is_cfg_type(nxt1.octet)
                       && is_clean_data(nxt2) && is_clean_data(nxt3);

        if (head_ok && idle_tail_ok)        cls = CLS_IDLE;
        else if (head_ok && cfg_tail_ok)    cls = CLS_CFG;
        else if (looks_like_start(lead))    cls = CLS_SUSPECT;
        else                                cls = CLS_OTHER;
    end

endmodule

// File: rtl/osd_flag_tracker.sv
module osd_flag_tracker
    import osd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cls_e cls,
    output set_e kind_q
);

    set_e             mode_q;
    set_e             cur_q;
    logic [CNT_W-1:0] rem_q;

    set_e             start_kind;
    set_e             start_mode;
    logic [CNT_W-1:0] start_rem;

    always_comb begin
        start_kind = SET_NONE;
        start_mode = SET_NONE;
        start_rem  = '0;
        unique case (cls)
            CLS_IDLE: begin
                start_kind = SET_IDLE;
                start_mode = SET_IDLE;
                start_rem  = tail_len(SET_IDLE);
            end
            CLS_CFG: begin
                start_kind = SET_CFG;
                start_mode = SET_CFG;
                start_rem  = tail_len(SET_CFG);
            end
            CLS_SUSPECT: begin
                if (mode_q != SET_NONE) begin
                    start_kind = SET_BAD;
                    start_mode = mode_q;
                    start_rem  = tail_len(mode_q);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SET_NONE;
            cur_q  <= SET_NONE;
            kind_q <= SET_NONE;
            rem_q  <= '0;
        end else if (rem_q != '0) begin
            rem_q  <= rem_q - CNT_W'(1);
            kind_q <= cur_q;
        end else begin
            rem_q  <= start_rem;
            cur_q  <= start_kind;
            kind_q <= start_kind;
            mode_q <= start_mode;
        end
    end

endmodule

// File: rtl/osd_rx_status.sv
module osd_rx_status
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_octet,
    input  logic              rx_ctrl,
    input  logic              rx_viol,
    output logic [BYTE_W-1:0] rxd_out,
    output logic              stat_cfg,
    output logic              stat_idle,
    output logic              stat_invalid
);

    localparam int LEAD_TAP = PIPE_DEPTH - 2;

    cgrp_t                  din;
    cgrp_t [PIPE_DEPTH-1:0] taps;
    cls_e                   cls;
    set_e                   kind_q;

    assign din = '{octet: rx_octet, ctrl: rx_ctrl, viol: rx_viol};

    osd_tap_line #(.DEPTH(PIPE_DEPTH)) u_taps (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .taps (taps)
    );

    // The group about to be output sits at LEAD_TAP; the three groups
    // behind it are the two younger taps and the live input.
    osd_set_classifier u_cls (
        .lead (taps[LEAD_TAP]),
        .nxt1 (taps[LEAD_TAP-1]),
        .nxt2 (taps[LEAD_TAP-2]),
        .nxt3 (din),
        .cls  (cls)
    );

    osd_flag_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .cls    (cls),
        .kind_q (kind_q)
    );

    assign rxd_out      = taps[PIPE_DEPTH-1].octet;
    assign stat_cfg     = (kind_q == SET_CFG);
    assign stat_idle    = (kind_q == SET_IDLE);
    assign stat_invalid = (kind_q == SET_BAD);

endmodule

// File: rtl/osd_rx_status_sva.sv
module osd_rx_status_sva
    import osd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] rx_octet,
    input logic [BYTE_W-1:0] rxd_out,
    input logic              stat_cfg,
    input logic              stat_idle,
    input logic              stat_invalid
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stat_cfg, stat_idle, stat_invalid}));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (rxd_out == '0) && !stat_cfg && !stat_idle && !stat_invalid);

    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (rxd_out == $past(rx_octet, 4)));

    p_idle_tail_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_idle && rxd_out == COMMA_OCT) |=> (stat_idle && rxd_out == IDLE_OCT));

    p_cfg_tail_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_cfg && rxd_out == COMMA_OCT)
        |=> (stat_cfg && is_cfg_type(rxd_out)) ##1 stat_cfg ##1 stat_cfg);

endmodule

bind osd_rx_status osd_rx_status_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .rx_octet     (rx_octet),
    .rxd_out      (rxd_out),
    .stat_cfg     (stat_cfg),
    .stat_idle    (stat_idle),
    .stat_invalid (stat_invalid)
);

// File: tb/osd_rx_status_bench.sv
module osd_rx_status_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] rx_octet;
    logic       rx_ctrl;
    logic       rx_viol;
    logic [7:0] rxd_out;
    logic       stat_cfg, stat_idle, stat_invalid;

    always #5 clk = ~clk;

    osd_rx_status u_osd_rx_status (
        .clk          (clk),
        .rst          (rst),
        .rx_octet     (rx_octet),
        .rx_ctrl      (rx_ctrl),
        .rx_viol      (rx_viol),
        .rxd_out      (rxd_out),
        .stat_cfg     (stat_cfg),
        .stat_idle    (stat_idle),
        .stat_invalid (stat_invalid)
    );

    typedef struct {
        logic [7:0] b;
        logic       k;
        logic       e;
        string      tag;
    } stim_t;

    typedef struct {
        logic [7:0] b;
        logic [2:0] fl;   // {cfg, idle, invalid}
        string      tag;
    } exp_t;

    stim_t stim[$];
    exp_t  sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic  drv_valid = 1'b0;
    logic [3:0] vtag = 4'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic put(input logic [7:0] b, input logic k, input logic e, input string tag);
        stim_t s;
        s.b = b; s.k = k; s.e = e; s.tag = tag;
        stim.push_back(s);
    endtask

    task automatic idle_set(input string tag);
        put(8'hBC, 1'b1, 1'b0, tag);
        put(8'h50, 1'b0, 1'b0, tag);
    endtask

    task automatic cfg_set(input logic [7:0] typ, input logic [7:0] w0, input logic [7:0] w1,
                           input string tag);
        put(8'hBC, 1'b1, 1'b0, tag);
        put(typ,   1'b0, 1'b0, tag);
        put(w0,    1'b0, 1'b0, tag);
        put(w1,    1'b0, 1'b0, tag);
    endtask

    function automatic stim_t at(input int j);
        stim_t s;
        if (j < stim.size()) return stim[j];
        s.b = 8'h00; s.k = 1'b0; s.e = 1'b0; s.tag = "pad";
        return s;
    endfunction

    function automatic bit clean(input stim_t s);
        return !s.k && !s.e;
    endfunction

    // Reference model from R2..R6: mode 0 none, 1 idle, 2 configuration.
    task automatic build_expected();
        int mode = 0;
        int rem  = 0;
        logic [2:0] cur = 3'b000;
        for (int i = 0; i < stim.size(); i++) begin
            stim_t g;
            exp_t  x;
            bit    comma;
            g = at(i);
            comma = (g.b == 8'hBC) && g.k && !g.e;
            if (rem > 0) begin
                rem--;
            end else if (comma && clean(at(i+1)) && at(i+1).b == 8'h50) begin
                cur = 3'b010; rem = 1; mode = 1;
            end else if (comma && clean(at(i+1)) && (at(i+1).b == 8'hB5 || at(i+1).b == 8'h42)
                         && clean(at(i+2)) && clean(at(i+3))) begin
                cur = 3'b100; rem = 3; mode = 2;
            end else if ((g.e || (g.k && g.b == 8'hBC)) && mode != 0) begin
                cur = 3'b001; rem = (mode == 1) ? 1 : 3;
            end else begin
                cur = 3'b000; rem = 0; mode = 0;
            end
            x.b = g.b; x.fl = cur; x.tag = g.tag;
            sb.push_back(x);
        end
    endtask

    // Monitor: the group driven before edge N appears after edge N+3.
    always @(posedge clk) begin
        vtag = {vtag[2:0], drv_valid};
        #1;
        if (vtag[3] && !rst) begin
            if (sb.size() == 0) begin
                check("R1", "unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R1", "byte", int'(rxd_out), int'(e.b));
                check(e.tag, "flags {cfg,idle,inv}",
                      int'({stat_cfg, stat_idle, stat_invalid}), int'(e.fl));
                check("R7", "flag exclusivity",
                      int'($countones({stat_cfg, stat_idle, stat_invalid}) <= 1), 1);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rx_octet = 8'hBC; rx_ctrl = 1'b1; rx_viol = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "reset byte",  int'(rxd_out), 0);
        check("R8", "reset flags", int'({stat_cfg, stat_idle, stat_invalid}), 0);

        // R6: plain data and a corrupted comma with no traffic in progress
        put(8'h11, 1'b0, 1'b0, "R6"); put(8'h22, 1'b0, 1'b0, "R6"); put(8'h33, 1'b0, 1'b0, "R6");
        put(8'hBC, 1'b1, 1'b1, "R6"); put(8'h50, 1'b0, 1'b0, "R6");
        // R2: clean idles
        idle_set("R2"); idle_set("R2"); idle_set("R2");
        // R5: violation on the idle data byte
        put(8'hBC, 1'b1, 1'b0, "R5"); put(8'h50, 1'b0, 1'b1, "R5");
        idle_set("R2");
        // R4: wrong idle data byte, then a lone violation at a boundary
        put(8'hBC, 1'b1, 1'b0, "R4"); put(8'h51, 1'b0, 1'b0, "R4");
        idle_set("R2");
        put(8'h50, 1'b0, 1'b1, "R4"); put(8'h50, 1'b0, 1'b0, "R4");
        // R6: start-of-packet delimiter and payload end the idle run
        put(8'hFB, 1'b1, 1'b0, "R6");
        put(8'h55, 1'b0, 1'b0, "R6"); put(8'hD5, 1'b0, 1'b0, "R6"); put(8'h01, 1'b0, 1'b0, "R6");
        // R3: alternating configuration sets
        cfg_set(8'hB5, 8'h01, 8'h80, "R3"); cfg_set(8'h42, 8'h01, 8'h80, "R3");
        cfg_set(8'hB5, 8'h20, 8'h40, "R3"); cfg_set(8'h42, 8'h20, 8'h40, "R3");
        // R5: control character in a configuration-word position
        put(8'hBC, 1'b1, 1'b0, "R5"); put(8'hB5, 1'b0, 1'b0, "R5");
        put(8'h1C, 1'b1, 1'b0, "R5"); put(8'h00, 1'b0, 1'b0, "R5");
        cfg_set(8'h42, 8'h00, 8'h00, "R3");
        // R5: violation in the last word byte
        put(8'hBC, 1'b1, 1'b0, "R5"); put(8'hB5, 1'b0, 1'b0, "R5");
        put(8'h12, 1'b0, 1'b0, "R5"); put(8'h34, 1'b0, 1'b1, "R5");
        // R4: comma with a violation while configuration traffic runs
        put(8'hBC, 1'b1, 1'b1, "R4"); put(8'h42, 1'b0, 1'b0, "R4");
        put(8'h11, 1'b0, 1'b0, "R4"); put(8'h22, 1'b0, 1'b0, "R4");
        cfg_set(8'hB5, 8'h9A, 8'h07, "R3");
        // R2: switch to idles
        idle_set("R2"); idle_set("R2");
        // R6: data ends traffic; later violations are not flagged
        put(8'h77, 1'b0, 1'b0, "R6"); put(8'h78, 1'b0, 1'b1, "R6");
        put(8'hBC, 1'b1, 1'b0, "R6"); put(8'h66, 1'b0, 1'b0, "R6");
        put(8'h99, 1'b0, 1'b0, "R6");

        build_expected();

        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < stim.size(); i++) begin
            rx_octet  = stim[i].b;
            rx_ctrl   = stim[i].k;
            rx_viol   = stim[i].e;
            drv_valid = 1'b1;
            @(negedge clk);
        end
        rx_octet = 8'h00; rx_ctrl = 1'b0; rx_viol = 1'b0; drv_valid = 1'b0;
        repeat (8) @(negedge clk);
        check("R1", "items left in scoreboard", sb.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule